// File: doc/BRIEF.md
# Hybrid VID Mode Controller

This block holds the digital configuration and reference-selection logic of a dual-plane CPU voltage regulator controller. The controller serves processors that program their supply voltages either through six static parallel VID lines or through a two-wire serial voltage-ID link. On each rising edge of the enable input the block decides the operating mode from VID line 1 and takes the core phase count from which PWM outputs are strapped to ground. In serial mode it also latches a 2-bit boot code taken from the serial clock and data lines. It then drives a core reference code and a north-bridge (NB) reference code, together with the high-impedance and driver-enable controls for both planes.

In parallel mode only the core plane regulates and the NB plane stays in high impedance. In serial mode both planes first regulate to the latched boot code while the system power-good input is low. Once that input is high, they follow the codes delivered by an upstream serial decoder, which flags each new command with a one-cycle strobe. If the power-good input drops again, both planes return to the latched boot code. A hardware fixed-voltage strap overrides every VID code and selects a fixed overvoltage threshold.

The control state machine has five states:
- OFF: enable low, every output in its safe state.
- ARM: one cycle after the enable sample.
- PAR_RUN: parallel mode running.
- BOOT_RUN: serial mode, power-good input low.
- SVI_RUN: serial mode, power-good input high.

Its transitions are:
- OFF to ARM on enable high.
- ARM to PAR_RUN when the sampled mode bit is 0.
- ARM to BOOT_RUN or SVI_RUN, chosen by the power-good input, when the mode bit is 1.
- BOOT_RUN to SVI_RUN when power-good rises.
- SVI_RUN to BOOT_RUN when power-good falls.
- Any state to OFF whenever enable is low.

Top module: `hvid_mode_ctrl`

## Requirements
- R1: While enable is low, and after reset, every output is in its safe state: core_ref and nb_ref are 0, core_drv_en, nb_drv_en, mode_valid, ovp_fix and vid_done are 0, core_hiz and nb_hiz are 1, and phase_en is 0.
- R2: At the first clock edge where enable is high after being low, vid_in[1] is sampled: 1 selects serial mode (serial_mode=1) and 0 selects parallel mode. The mode then holds, whatever vid_in[1] does, until enable goes low.
- R3: mode_valid rises one clock after the sampling edge. It falls at the first edge at which enable is sampled low.
- R4: In parallel mode core_ref is {2'b00, vid_in[5:0]}, following the lines. core_drv_en is 1 and core_hiz is 0. The NB plane stays at nb_hiz=1, nb_drv_en=0 and nb_ref=0.
- R5: In serial mode, at the sampling edge, the boot code {vid_in[3] (clock line), vid_in[2] (data line)} is latched. While power-good is low, core_ref and nb_ref both equal 8'h80 OR that 2-bit code. Later changes on the VID lines do not alter it.
- R6: In serial mode vid_in[0], vid_in[4] and vid_in[5] have no effect on any reference. Both planes are enabled and out of high impedance.
- R7: In serial mode with power-good high, the references hold their value until svi_valid_in is high at a clock edge. At that edge they take svi_core_in and svi_nb_in, and vid_done is 1 for exactly the following cycle.
- R8: When power-good falls in serial mode, both references return at the next edge to the boot code latched when enable rose. Only an enable cycle re-samples the boot code.
- R9: While mode_valid is 1 and vfix_in is 1, ovp_fix is 1 and core_ref is 8'hC0 OR {vid_in[3], vid_in[2]}, following the lines. In serial mode nb_ref carries the same value; in parallel mode nb_ref stays 0.
- R10: At the sampling edge the phase count is set from pwm_gnd_in (bit 0 = phase-3 PWM grounded, bit 1 = phase-4 PWM grounded). The count is 4 by default, 3 when only bit 1 is set, and 2 when both bits are set. phase_en has that many low bits set while running.
- R11: A strobe on svi_valid_in while power-good is low, or in parallel mode, changes no reference and raises no vid_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply power cycle) |
| en_in | input | 1 | Regulator enable |
| vid_in | input | 6 | Parallel VID lines; bit 2 = serial data, bit 3 = serial clock |
| pwrok_in | input | 1 | System power-good input |
| vfix_in | input | 1 | Fixed-voltage hardware strap |
| svi_valid_in | input | 1 | One-cycle strobe from serial decoder: new codes valid |
| svi_core_in | input | 8 | Decoded core code from the serial decoder |
| svi_nb_in | input | 8 | Decoded NB code from the serial decoder |
| pwm_gnd_in | input | 2 | Ground-strap sense of PWM outputs 3 (bit 0) and 4 (bit 1) |
| core_ref | output | 8 | Core plane reference code |
| nb_ref | output | 8 | NB plane reference code |
| serial_mode | output | 1 | 1 = serial mode, 0 = parallel mode |
| mode_valid | output | 1 | Mode sample taken and regulator running |
| core_hiz | output | 1 | Core PWM outputs in high impedance |
| nb_hiz | output | 1 | NB PWM output in high impedance |
| core_drv_en | output | 1 | Core external driver enable |
| nb_drv_en | output | 1 | NB external driver enable |
| phase_en | output | 4 | Per-phase enable mask for the core plane |
| phase_cnt | output | 3 | Active core phase count |
| ovp_fix | output | 1 | Fixed overvoltage threshold selected |
| vid_done | output | 1 | Pulse: new serial code has taken effect |

## Verification
The reference selection is tried with two parallel VID words and a third that toggles line 1 while running. The parallel words show that the code follows the lines; the toggle shows that the mode does not move. The serial boot path is tried with two different clock/data patterns across an enable cycle, and with noise on lines 0, 4 and 5 and on the serial lines after latching. This separates a latched boot code from a live decode. Serial commands are applied with strobes before and after power-good rises and with code changes that carry no strobe, which tells a strobe-gated update from a level-following one. Three strap patterns distinguish the 4-, 3- and 2-phase decodes.

// File: rtl/hvid_pkg.sv
package hvid_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM,
        ST_PAR_RUN,
        ST_BOOT_RUN,
        ST_SVI_RUN
    } hvid_state_t;

    function automatic logic is_running(input hvid_state_t s);
        return (s == ST_PAR_RUN) || (s == ST_BOOT_RUN) || (s == ST_SVI_RUN);
    endfunction

    function automatic logic is_serial_running(input hvid_state_t s);
        return (s == ST_BOOT_RUN) || (s == ST_SVI_RUN);
    endfunction

endpackage

// File: rtl/hvid_phase_detect.sv
module hvid_phase_detect #(
    parameter int NPH = 4,
    localparam int CNT_W = $clog2(NPH + 1)
) (
    input  logic [1:0]       gnd_sense,
    output logic [CNT_W-1:0] cnt,
    output logic [NPH-1:0]   mask
);

    always_comb begin
        if (gnd_sense[1] && gnd_sense[0]) begin
            cnt = CNT_W'(NPH - 2);
        end else if (gnd_sense[1]) begin
            cnt = CNT_W'(NPH - 1);
        end else begin
            cnt = CNT_W'(NPH);
        end
    end

    for (genvar i = 0; i < NPH; i++) begin : g_mask
        assign mask[i] = (CNT_W'(i) < cnt);
    end

endmodule

// File: rtl/hvid_svi_track.sv
module hvid_svi_track #(
    parameter int REF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tracking,
    input  logic [REF_W-1:0] boot_code,
    input  logic             strobe,
    input  logic [REF_W-1:0] core_cmd,
    input  logic [REF_W-1:0] nb_cmd,
    output logic [REF_W-1:0] core_q,
    output logic [REF_W-1:0] nb_q,
    output logic             done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
            nb_q   <= '0;
            done   <= 1'b0;
        end else if (!tracking) begin
            core_q <= boot_code;
            nb_q   <= boot_code;
            done   <= 1'b0;
        end else if (strobe) begin
            core_q <= core_cmd;
            nb_q   <= nb_cmd;
            done   <= 1'b1;
        end else begin
            done   <= 1'b0;
        end
    end

endmodule

// File: rtl/hvid_ref_mux.sv
module hvid_ref_mux
    import hvid_pkg::*;
#(
    parameter int REF_W = 8,
    parameter int PAR_W = 6,
    parameter int SC_IDX = 3,
    parameter int SD_IDX = 2
) (
    input  hvid_state_t      state,
    input  logic [PAR_W-1:0] vid,
    input  logic [1:0]       boot_bits,
    input  logic             vfix,
    input  logic [REF_W-1:0] svi_core,
    input  logic [REF_W-1:0] svi_nb,
    output logic [REF_W-1:0] boot_code,
    output logic [REF_W-1:0] core_ref,
    output logic [REF_W-1:0] nb_ref,
    output logic             ovp_fix
);

    localparam logic [REF_W-1:0] BOOT_TAG = {2'b10, {(REF_W-2){1'b0}}};
    localparam logic [REF_W-1:0] VFIX_TAG = {2'b11, {(REF_W-2){1'b0}}};

    logic [REF_W-1:0] vfix_code;

    assign boot_code = BOOT_TAG | REF_W'(boot_bits);
    assign vfix_code = VFIX_TAG | REF_W'({vid[SC_IDX], vid[SD_IDX]});

    always_comb begin
        core_ref = '0;
        nb_ref   = '0;
        ovp_fix  = 1'b0;
        unique case (state)
            ST_OFF, ST_ARM: begin
                core_ref = '0;
                nb_ref   = '0;
            end
            ST_PAR_RUN: begin
                core_ref = REF_W'(vid);
                nb_ref   = '0;
            end
            ST_BOOT_RUN: begin
                core_ref = boot_code;
                nb_ref   = boot_code;
            end
            ST_SVI_RUN: begin
                core_ref = svi_core;
                nb_ref   = svi_nb;
            end
            default: begin
                core_ref = '0;
                nb_ref   = '0;
            end
        endcase
        if (vfix && is_running(state)) begin
            ovp_fix  = 1'b1;
            core_ref = vfix_code;
            nb_ref   = is_serial_running(state) ? vfix_code : '0;
        end
    end

endmodule

// File: rtl/hvid_mode_ctrl.sv
module hvid_mode_ctrl
    import hvid_pkg::*;
#(
    parameter int REF_W = 8,
    parameter int PAR_W = 6,
    parameter int NPH   = 4,
    localparam int CNT_W = $clog2(NPH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic [PAR_W-1:0] vid_in,
    input  logic             pwrok_in,
    input  logic             vfix_in,
    input  logic             svi_valid_in,
    input  logic [REF_W-1:0] svi_core_in,
    input  logic [REF_W-1:0] svi_nb_in,
    input  logic [1:0]       pwm_gnd_in,
    output logic [REF_W-1:0] core_ref,
    output logic [REF_W-1:0] nb_ref,
    output logic             serial_mode,
    output logic             mode_valid,
    output logic             core_hiz,
    output logic             nb_hiz,
    output logic             core_drv_en,
    output logic             nb_drv_en,
    output logic [NPH-1:0]   phase_en,
    output logic [CNT_W-1:0] phase_cnt,
    output logic             ovp_fix,
    output logic             vid_done
);

    localparam int SEL_IDX = 1;
    localparam int SD_IDX  = 2;
    localparam int SC_IDX  = 3;

    hvid_state_t      state, state_nx;
    logic             ser_q;
    logic [1:0]       boot_q;
    logic [CNT_W-1:0] ph_cnt_q, ph_cnt_det;
    logic [NPH-1:0]   ph_mask_q, ph_mask_det;
    logic [REF_W-1:0] boot_code, svi_core_q, svi_nb_q;
    logic             take_sample;

    assign take_sample = (state == ST_OFF) && en_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:      state_nx = en_in ? ST_ARM : ST_OFF;
            ST_ARM: begin
                if (!en_in)        state_nx = ST_OFF;
                else if (!ser_q)   state_nx = ST_PAR_RUN;
                else if (pwrok_in) state_nx = ST_SVI_RUN;
                else               state_nx = ST_BOOT_RUN;
            end
            ST_PAR_RUN:  state_nx = en_in ? ST_PAR_RUN : ST_OFF;
            ST_BOOT_RUN: begin
                if (!en_in)        state_nx = ST_OFF;
                else if (pwrok_in) state_nx = ST_SVI_RUN;
                else               state_nx = ST_BOOT_RUN;
            end
            ST_SVI_RUN: begin
                if (!en_in)         state_nx = ST_OFF;
                else if (!pwrok_in) state_nx = ST_BOOT_RUN;
                else                state_nx = ST_SVI_RUN;
            end
            default:     state_nx = ST_OFF;
        endcase
    end

    // configuration captured on the enable sample, cleared while off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q     <= 1'b0;
            boot_q    <= 2'b00;
            ph_cnt_q  <= '0;
            ph_mask_q <= '0;
        end else if (take_sample) begin
            ser_q     <= vid_in[SEL_IDX];
            boot_q    <= {vid_in[SC_IDX], vid_in[SD_IDX]};
            ph_cnt_q  <= ph_cnt_det;
            ph_mask_q <= ph_mask_det;
        end else if (state == ST_OFF) begin
            ser_q     <= 1'b0;
            boot_q    <= 2'b00;
            ph_cnt_q  <= '0;
            ph_mask_q <= '0;
        end
    end

    hvid_phase_detect #(.NPH(NPH)) u_phase (
        .gnd_sense (pwm_gnd_in),
        .cnt       (ph_cnt_det),
        .mask      (ph_mask_det)
    );

    hvid_svi_track #(.REF_W(REF_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .tracking  (state == ST_SVI_RUN),
        .boot_code (boot_code),
        .strobe    (svi_valid_in),
        .core_cmd  (svi_core_in),
        .nb_cmd    (svi_nb_in),
        .core_q    (svi_core_q),
        .nb_q      (svi_nb_q),
        .done      (vid_done)
    );

    hvid_ref_mux #(
        .REF_W  (REF_W),
        .PAR_W  (PAR_W),
        .SC_IDX (SC_IDX),
        .SD_IDX (SD_IDX)
    ) u_mux (
        .state     (state),
        .vid       (vid_in),
        .boot_bits (boot_q),
        .vfix      (vfix_in),
        .svi_core  (svi_core_q),
        .svi_nb    (svi_nb_q),
        .boot_code (boot_code),
        .core_ref  (core_ref),
        .nb_ref    (nb_ref),
        .ovp_fix   (ovp_fix)
    );

    // state-decoded outputs
    always_comb begin
        mode_valid  = 1'b0;
        serial_mode = 1'b0;
        core_hiz    = 1'b1;
        nb_hiz      = 1'b1;
        core_drv_en = 1'b0;
        nb_drv_en   = 1'b0;
        phase_en    = '0;
        phase_cnt   = '0;
        unique case (state)
            ST_OFF, ST_ARM: begin
                mode_valid = 1'b0;
            end
            ST_PAR_RUN: begin
                mode_valid  = 1'b1;
                core_hiz    = 1'b0;
                core_drv_en = 1'b1;
                phase_en    = ph_mask_q;
                phase_cnt   = ph_cnt_q;
            end
            ST_BOOT_RUN, ST_SVI_RUN: begin
                mode_valid  = 1'b1;
                serial_mode = 1'b1;
                core_hiz    = 1'b0;
                nb_hiz      = 1'b0;
                core_drv_en = 1'b1;
                nb_drv_en   = 1'b1;
                phase_en    = ph_mask_q;
                phase_cnt   = ph_cnt_q;
            end
            default: begin
                mode_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hvid_mode_ctrl_chk.sv
module hvid_mode_ctrl_chk #(
    parameter int REF_W = 8,
    parameter int PAR_W = 6,
    parameter int NPH   = 4,
    localparam int CNT_W = $clog2(NPH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_in,
    input logic             pwrok_in,
    input logic             vfix_in,
    input logic             svi_valid_in,
    input logic [REF_W-1:0] core_ref,
    input logic [REF_W-1:0] nb_ref,
    input logic             serial_mode,
    input logic             mode_valid,
    input logic             core_hiz,
    input logic             nb_hiz,
    input logic             core_drv_en,
    input logic             nb_drv_en,
    input logic [NPH-1:0]   phase_en,
    input logic [CNT_W-1:0] phase_cnt,
    input logic             ovp_fix,
    input logic             vid_done
);

    // R1
    off_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> (core_ref == '0) && (nb_ref == '0) && !core_drv_en
                        && !nb_drv_en && core_hiz && nb_hiz && (phase_en == '0));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && $past(mode_valid)) |-> $stable(serial_mode));

    // R3
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_valid) |-> ($past(en_in) && $past(en_in, 2)));

    // R3
    en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |=> !mode_valid);

    // R4
    par_nb_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && !serial_mode) |-> (nb_hiz && !nb_drv_en && (nb_ref == '0)));

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_done |-> ($past(svi_valid_in) && serial_mode && $past(pwrok_in)));

    // R9
    vfix_ovp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && vfix_in) |-> ovp_fix);

    // R10
    phase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |-> ($countones(phase_en) == int'(phase_cnt)));

    // R11
    strobe_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && !pwrok_in && $past(mode_valid) && !$past(pwrok_in)) |-> !vid_done);

endmodule

bind hvid_mode_ctrl hvid_mode_ctrl_chk #(
    .REF_W (REF_W),
    .PAR_W (PAR_W),
    .NPH   (NPH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_in        (en_in),
    .pwrok_in     (pwrok_in),
    .vfix_in      (vfix_in),
    .svi_valid_in (svi_valid_in),
    .core_ref     (core_ref),
    .nb_ref       (nb_ref),
    .serial_mode  (serial_mode),
    .mode_valid   (mode_valid),
    .core_hiz     (core_hiz),
    .nb_hiz       (nb_hiz),
    .core_drv_en  (core_drv_en),
    .nb_drv_en    (nb_drv_en),
    .phase_en     (phase_en),
    .phase_cnt    (phase_cnt),
    .ovp_fix      (ovp_fix),
    .vid_done     (vid_done)
);

// File: tb/hvid_mode_ctrl_test.sv
`timescale 1ns/1ps
module hvid_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_in = 1'b0;
    logic [5:0] vid_in = '0;
    logic       pwrok_in = 1'b0;
    logic       vfix_in = 1'b0;
    logic       svi_valid_in = 1'b0;
    logic [7:0] svi_core_in = '0;
    logic [7:0] svi_nb_in = '0;
    logic [1:0] pwm_gnd_in = '0;
    logic [7:0] core_ref, nb_ref;
    logic       serial_mode, mode_valid, core_hiz, nb_hiz;
    logic       core_drv_en, nb_drv_en, ovp_fix, vid_done;
    logic [3:0] phase_en;
    logic [2:0] phase_cnt;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    hvid_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en_in(en_in), .vid_in(vid_in),
        .pwrok_in(pwrok_in), .vfix_in(vfix_in), .svi_valid_in(svi_valid_in),
        .svi_core_in(svi_core_in), .svi_nb_in(svi_nb_in), .pwm_gnd_in(pwm_gnd_in),
        .core_ref(core_ref), .nb_ref(nb_ref), .serial_mode(serial_mode),
        .mode_valid(mode_valid), .core_hiz(core_hiz), .nb_hiz(nb_hiz),
        .core_drv_en(core_drv_en), .nb_drv_en(nb_drv_en), .phase_en(phase_en),
        .phase_cnt(phase_cnt), .ovp_fix(ovp_fix), .vid_done(vid_done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_safe(input string tag);
        chk({tag, " core_ref"}, 32'(core_ref), 32'h0);
        chk({tag, " nb_ref"}, 32'(nb_ref), 32'h0);
        chk({tag, " drv"}, {30'd0, core_drv_en, nb_drv_en}, 32'h0);
        chk({tag, " hiz"}, {30'd0, core_hiz, nb_hiz}, 32'h3);
        chk({tag, " valid"}, {31'd0, mode_valid}, 32'h0);
        chk({tag, " phase_en"}, 32'(phase_en), 32'h0);
    endtask

    task automatic enable_with(input logic [5:0] v, input logic [1:0] gnd);
        vid_in = v;
        pwm_gnd_in = gnd;
        en_in = 1'b1;
        tick();
        chk("R3 mode_valid low in sample cycle", {31'd0, mode_valid}, 32'h0);
        tick();
        chk("R3 mode_valid high one clock later", {31'd0, mode_valid}, 32'h1);
    endtask

    task automatic disable_en();
        en_in = 1'b0;
        tick();
        check_safe("R1 after enable drop");
        chk("R3 mode_valid fall", {31'd0, mode_valid}, 32'h0);
    endtask

    task automatic t_reset();
        check_safe("R1 reset");
        chk("R1 ovp_fix", {31'd0, ovp_fix}, 32'h0);
        chk("R1 vid_done", {31'd0, vid_done}, 32'h0);
    endtask

    task automatic t_parallel();
        enable_with(6'b101101, 2'b00);
        chk("R2 parallel mode", {31'd0, serial_mode}, 32'h0);
        chk("R4 core_ref", 32'(core_ref), 32'h2D);
        chk("R4 nb_ref", 32'(nb_ref), 32'h0);
        chk("R4 nb_hiz/nb_drv", {30'd0, nb_hiz, nb_drv_en}, 32'h2);
        chk("R4 core_drv/core_hiz", {30'd0, core_drv_en, core_hiz}, 32'h2);
        chk("R10 default 4 phases", 32'(phase_cnt), 32'd4);
        chk("R10 mask 4", 32'(phase_en), 32'hF);
        vid_in = 6'b010100;
        tick();
        chk("R4 core_ref follows", 32'(core_ref), 32'h14);
        vid_in = 6'b010110;
        tick();
        tick();
        chk("R2 mode held on vid1 toggle", {31'd0, serial_mode}, 32'h0);
        chk("R4 core_ref with vid1 set", 32'(core_ref), 32'h16);
        svi_core_in = 8'h55;
        svi_valid_in = 1'b1;
        tick();
        svi_valid_in = 1'b0;
        chk("R11 strobe ignored in parallel", 32'(core_ref), 32'h16);
        chk("R11 no done in parallel", {31'd0, vid_done}, 32'h0);
        vfix_in = 1'b1;
        vid_in = 6'b000100;
        #1;
        chk("R9 vfix core_ref parallel", 32'(core_ref), 32'hC1);
        chk("R9 vfix nb_ref parallel", 32'(nb_ref), 32'h0);
        chk("R9 ovp_fix", {31'd0, ovp_fix}, 32'h1);
        vfix_in = 1'b0;
        disable_en();
    endtask

    task automatic t_phases();
        enable_with(6'b000000, 2'b10);
        chk("R10 pwm4 grounded -> 3", 32'(phase_cnt), 32'd3);
        chk("R10 mask 3", 32'(phase_en), 32'h7);
        pwm_gnd_in = 2'b00;
        tick();
        chk("R10 count held after strap change", 32'(phase_cnt), 32'd3);
        disable_en();
        enable_with(6'b000000, 2'b11);
        chk("R10 both grounded -> 2", 32'(phase_cnt), 32'd2);
        chk("R10 mask 2", 32'(phase_en), 32'h3);
        disable_en();
        pwm_gnd_in = 2'b00;
    endtask

    task automatic t_serial_boot();
        pwrok_in = 1'b0;
        enable_with(6'b001010, 2'b00);
        chk("R2 serial mode", {31'd0, serial_mode}, 32'h1);
        chk("R5 boot core_ref", 32'(core_ref), 32'h82);
        chk("R5 boot nb_ref", 32'(nb_ref), 32'h82);
        chk("R6 nb enabled", {30'd0, nb_drv_en, nb_hiz}, 32'h2);
        vid_in = 6'b110111;
        tick();
        chk("R6 vid0/4/5 ignored, R5 latch held core", 32'(core_ref), 32'h82);
        chk("R6 vid0/4/5 ignored nb", 32'(nb_ref), 32'h82);
        svi_core_in = 8'h3A;
        svi_nb_in = 8'h51;
        svi_valid_in = 1'b1;
        tick();
        svi_valid_in = 1'b0;
        chk("R11 strobe ignored in boot", 32'(core_ref), 32'h82);
        chk("R11 no done in boot", {31'd0, vid_done}, 32'h0);
    endtask

    task automatic t_serial_run();
        pwrok_in = 1'b1;
        tick();
        chk("R7 boot code held until strobe", 32'(core_ref), 32'h82);
        svi_valid_in = 1'b1;
        tick();
        svi_valid_in = 1'b0;
        chk("R7 core takes command", 32'(core_ref), 32'h3A);
        chk("R7 nb takes command", 32'(nb_ref), 32'h51);
        chk("R7 done pulse", {31'd0, vid_done}, 32'h1);
        svi_core_in = 8'h77;
        svi_nb_in = 8'h66;
        tick();
        chk("R7 done one cycle", {31'd0, vid_done}, 32'h0);
        chk("R7 no update without strobe", 32'(core_ref), 32'h3A);
        vfix_in = 1'b1;
        vid_in = 6'b001110;
        #1;
        chk("R9 vfix core serial", 32'(core_ref), 32'hC3);
        chk("R9 vfix nb serial", 32'(nb_ref), 32'hC3);
        vfix_in = 1'b0;
        #1;
        chk("R9 vfix release", 32'(core_ref), 32'h3A);
    endtask

    task automatic t_pwrok_drop();
        vid_in = 6'b000110;
        pwrok_in = 1'b0;
        tick();
        chk("R8 back to latched boot core", 32'(core_ref), 32'h82);
        chk("R8 back to latched boot nb", 32'(nb_ref), 32'h82);
        disable_en();
        enable_with(6'b000110, 2'b00);
        chk("R8 relatched after enable cycle", 32'(core_ref), 32'h81);
        disable_en();
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_parallel();
        t_phases();
        t_serial_boot();
        t_serial_run();
        t_pwrok_drop();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule